// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a host register port that issues 32-bit or 64-bit writes and a set of 128-bit control registers and a 64-bit-wide SRAM. Partial host writes are gathered in a collector: one target tag, a four-bit lane-valid mask and 128 bits of data. The wide target receives a single full-width commit strobe only once every lane has arrived. If a partial write for another wide target arrives while the collector is partly filled, the collector restarts on the new target and the earlier partial data is lost. The host must therefore serialise its wide writes.

Two per-queue descriptor-pointer registers get special treatment, so the host needs no lock for them. A write that touches their top dword always commits. If the collector and that write together do not supply all four lanes, the low 96 bits are sent as zero. A partial write to any other part of these registers is discarded when the collector is busy with a different target. Plain 32-bit registers (event pointer, timer command) pass straight through as a direct strobe. A parameterised erratum makes a timer-command write in page 0 wipe the collector.

The control logic is a three-state machine: EMPTY (nothing held), WIDE (a 128-bit register is partly held) and SRAM (a 64-bit SRAM word is partly held). The transitions are:
- open: EMPTY to WIDE or SRAM.
- merge: stay in the same state and add lanes.
- restart: WIDE or SRAM to WIDE or SRAM on a new tag.
- commit: back to EMPTY on a completed or top-dword write.
- drop: the collector stays as it is.
- invalidate: back to EMPTY on the erratum write.

Top module: `wcol_top`

## Requirements
- R1: After reset no commit strobe is high and the collector is empty: a three-lane partial write to a register that was never opened produces no commit.
- R2: An ordinary 128-bit register (region bit wr_addr[19]=0; in-page offset wr_addr[12:0] not in 0x400, 0x420, 0x830-0x83F, 0xA10-0xA1F) commits once all four dwords have been written, in any order. A dword is wr_qword=0 and lands in lane wr_addr[3:2], bits [32*lane+31:32*lane]. A qword is wr_qword=1 and fills lanes {wr_addr[3],0} and {wr_addr[3],1} from wr_data[31:0] and [63:32]. reg_addr is the address with bits [3:0] cleared.
- R3: Every commit strobe is high for exactly one cycle: the cycle after the clock edge that took the completing write.
- R4: A partial write to a different wide register while the collector is partly filled restarts the collector on the new register. Lanes already collected for the old register are lost.
- R5: A write with wr_addr[19]=1 targets the SRAM. Its lane is wr_addr[2]. A qword, or both dword halves in either order, raise sram_commit with sram_addr = wr_addr with bits [2:0] cleared.
- R6: A write covering lane 3 of a descriptor-pointer register (in-page base 0x830 or 0xA10) always commits it. If the lanes are not all present, bits [95:0] of reg_data are zero.
- R7: A descriptor-pointer register whose lanes 0-2 were collected first commits its full 128-bit value on the top-dword write.
- R8: A write to lanes 0-2 of a descriptor-pointer register while the collector holds a different target is discarded, and the collector keeps its tag and lanes.
- R9: A write to in-page offset 0x400 or 0x420 raises dir_commit with dir_addr = wr_addr and dir_data = wr_data[31:0]. It leaves the collector untouched, except as stated in R10.
- R10: With TIMER_ERRATUM=1 (the default), a write to in-page offset 0x420 in page 0 empties the collector. In any other page it does not.
- R11: Per-queue registers repeat every 0x2000 bytes: the page is wr_addr[18:13]. Descriptor-pointer handling applies in every page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write present this cycle |
| wr_addr | input | 20 | Host byte address; bit 19 selects the SRAM |
| wr_qword | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| wr_data | input | 64 | Write data; a dword uses bits [31:0] |
| reg_commit | output | 1 | Strobe: 128-bit register write |
| reg_addr | output | 20 | 16-byte-aligned register address |
| reg_data | output | 128 | Full register value |
| sram_commit | output | 1 | Strobe: 64-bit SRAM word write |
| sram_addr | output | 20 | 8-byte-aligned SRAM address |
| sram_data | output | 64 | SRAM word value |
| dir_commit | output | 1 | Strobe: plain 32-bit register write |
| dir_addr | output | 20 | Address of the plain register |
| dir_data | output | 32 | Data of the plain register |

## Verification
The hardest behaviour to reach is one that leaves no direct trace at the ports: a dropped descriptor write or an erratum-driven clear changes nothing visible at once. The stimulus therefore first opens a partial collection and then injects the disturbing write. It then finishes the original register and checks whether, and with which lanes, the commit appears. Random rounds scatter the dword or qword order of whole registers across random pages, and directed sequences set up the interleavings.

// File: rtl/wcol_pkg.sv
package wcol_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_WIDE,
        ST_SRAM
    } col_state_e;

    typedef enum logic [1:0] {
        CLS_WIDE,
        CLS_DESC,
        CLS_SRAM,
        CLS_DIRECT
    } wr_class_e;

    localparam int unsigned OFF_EVQ_PTR = 'h400;
    localparam int unsigned OFF_TIMER   = 'h420;
    localparam int unsigned OFF_RX_DPTR = 'h830;
    localparam int unsigned OFF_TX_DPTR = 'hA10;

endpackage

// File: rtl/wcol_decode.sv
module wcol_decode
    import wcol_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 13
) (
    input  logic [ADDR_W-1:2] addr,
    output wr_class_e         cls,
    output logic [ADDR_W-1:0] tag,
    output logic [1:0]        lane_idx,
    output logic              timer_p0
);
    localparam int PAGE_W = ADDR_W - 1 - PAGE_SHIFT;
    localparam logic [PAGE_SHIFT-1:0] L_EVQ = PAGE_SHIFT'(OFF_EVQ_PTR);
    localparam logic [PAGE_SHIFT-1:0] L_TMR = PAGE_SHIFT'(OFF_TIMER);
    localparam logic [PAGE_SHIFT-1:0] L_RXD = PAGE_SHIFT'(OFF_RX_DPTR);
    localparam logic [PAGE_SHIFT-1:0] L_TXD = PAGE_SHIFT'(OFF_TX_DPTR);

    logic                  is_sram;
    logic [PAGE_SHIFT-1:0] off;
    logic [PAGE_W-1:0]     page;
    logic [PAGE_SHIFT-1:0] off_blk;

    always_comb begin
        is_sram  = addr[ADDR_W-1];
        off      = {addr[PAGE_SHIFT-1:2], 2'b00};
        page     = addr[ADDR_W-2:PAGE_SHIFT];
        off_blk  = {off[PAGE_SHIFT-1:4], 4'h0};
        timer_p0 = !is_sram && (off == L_TMR) && (page == '0);
        if (is_sram) begin
            cls      = CLS_SRAM;
            tag      = {addr[ADDR_W-1:3], 3'b000};
            lane_idx = {1'b0, addr[2]};
        end else begin
            tag      = {addr[ADDR_W-1:4], 4'h0};
            lane_idx = addr[3:2];
            if (off == L_EVQ || off == L_TMR)
                cls = CLS_DIRECT;
            else if (off_blk == L_RXD || off_blk == L_TXD)
                cls = CLS_DESC;
            else
                cls = CLS_WIDE;
        end
    end
endmodule

// File: rtl/wcol_lanes.sv
module wcol_lanes #(
    parameter int LANE_W = 32,
    parameter int LANES  = 4
) (
    input  logic [LANES-1:0]        base_mask,
    input  logic [LANES*LANE_W-1:0] base_data,
    input  logic [1:0]              idx,
    input  logic                    qword,
    input  logic [2*LANE_W-1:0]     wdata,
    output logic [LANES-1:0]        wr_lanes,
    output logic [LANES-1:0]        mask_o,
    output logic [LANES*LANE_W-1:0] data_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit_lo, hit_hi;
        always_comb begin
            hit_lo = qword ? (2'(g) == {idx[1], 1'b0}) : (2'(g) == idx);
            hit_hi = qword && (2'(g) == {idx[1], 1'b1});
            wr_lanes[g] = hit_lo || hit_hi;
            mask_o[g]   = base_mask[g] || hit_lo || hit_hi;
            if (hit_lo)
                data_o[g*LANE_W +: LANE_W] = wdata[LANE_W-1:0];
            else if (hit_hi)
                data_o[g*LANE_W +: LANE_W] = wdata[2*LANE_W-1:LANE_W];
            else
                data_o[g*LANE_W +: LANE_W] = base_data[g*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/wcol_top.sv
module wcol_top
    import wcol_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int PAGE_SHIFT    = 13,
    parameter int LANE_W        = 32,
    parameter bit TIMER_ERRATUM = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                wr_qword,
    input  logic [2*LANE_W-1:0] wr_data,
    output logic                reg_commit,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic [4*LANE_W-1:0] reg_data,
    output logic                sram_commit,
    output logic [ADDR_W-1:0]   sram_addr,
    output logic [2*LANE_W-1:0] sram_data,
    output logic                dir_commit,
    output logic [ADDR_W-1:0]   dir_addr,
    output logic [LANE_W-1:0]   dir_data
);
    localparam int WIDE_W = 4 * LANE_W;
    localparam int KEEP_W = 3 * LANE_W;

    col_state_e          state, state_nx;
    logic [ADDR_W-1:0]   col_tag, col_tag_nx;
    logic [3:0]          col_mask, col_mask_nx;
    logic [WIDE_W-1:0]   col_data, col_data_nx;

    wr_class_e           cls;
    logic [ADDR_W-1:0]   tag;
    logic [1:0]          lane_idx;
    logic                timer_p0;
    logic                hit;
    logic [3:0]          base_mask, wr_lanes, mrg_mask;
    logic [WIDE_W-1:0]   base_data, mrg_data;

    logic                reg_go, sram_go, dir_go;
    logic [WIDE_W-1:0]   reg_val;

    wcol_decode #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_decode (
        .addr     (wr_addr[ADDR_W-1:2]),
        .cls      (cls),
        .tag      (tag),
        .lane_idx (lane_idx),
        .timer_p0 (timer_p0)
    );

    always_comb begin
        hit = (col_tag == tag) &&
              (((state == ST_SRAM) && (cls == CLS_SRAM)) ||
               ((state == ST_WIDE) && (cls == CLS_WIDE || cls == CLS_DESC)));
        base_mask = hit ? col_mask : 4'h0;
        base_data = hit ? col_data : '0;
    end

    wcol_lanes #(.LANE_W(LANE_W), .LANES(4)) u_lanes (
        .base_mask (base_mask),
        .base_data (base_data),
        .idx       (lane_idx),
        .qword     (wr_qword),
        .wdata     (wr_data),
        .wr_lanes  (wr_lanes),
        .mask_o    (mrg_mask),
        .data_o    (mrg_data)
    );

    // next-state and commit decision
    always_comb begin
        state_nx    = state;
        col_tag_nx  = col_tag;
        col_mask_nx = col_mask;
        col_data_nx = col_data;
        reg_go      = 1'b0;
        sram_go     = 1'b0;
        dir_go      = 1'b0;
        reg_val     = mrg_data;
        if (wr_valid) begin
            unique case (cls)
                CLS_DIRECT: begin
                    dir_go = 1'b1;
                    if (TIMER_ERRATUM && timer_p0) begin      // invalidate
                        state_nx    = ST_EMPTY;
                        col_mask_nx = 4'h0;
                    end
                end
                CLS_SRAM: begin
                    if (mrg_mask[1:0] == 2'b11) begin         // commit
                        sram_go     = 1'b1;
                        state_nx    = ST_EMPTY;
                        col_mask_nx = 4'h0;
                    end else begin                            // open/merge/restart
                        state_nx    = ST_SRAM;
                        col_tag_nx  = tag;
                        col_mask_nx = mrg_mask;
                        col_data_nx = mrg_data;
                    end
                end
                CLS_WIDE: begin
                    if (mrg_mask == 4'hF) begin               // commit
                        reg_go      = 1'b1;
                        state_nx    = ST_EMPTY;
                        col_mask_nx = 4'h0;
                    end else begin                            // open/merge/restart
                        state_nx    = ST_WIDE;
                        col_tag_nx  = tag;
                        col_mask_nx = mrg_mask;
                        col_data_nx = mrg_data;
                    end
                end
                CLS_DESC: begin
                    if (wr_lanes[3]) begin                    // commit, forced
                        reg_go      = 1'b1;
                        if (mrg_mask != 4'hF)
                            reg_val = {mrg_data[WIDE_W-1:KEEP_W], {KEEP_W{1'b0}}};
                        state_nx    = ST_EMPTY;
                        col_mask_nx = 4'h0;
                    end else if (state == ST_EMPTY || hit) begin  // open/merge
                        state_nx    = ST_WIDE;
                        col_tag_nx  = tag;
                        col_mask_nx = mrg_mask;
                        col_data_nx = mrg_data;
                    end
                    // otherwise: drop, collector untouched
                end
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_EMPTY;
            col_tag  <= '0;
            col_mask <= 4'h0;
            col_data <= '0;
        end else begin
            state    <= state_nx;
            col_tag  <= col_tag_nx;
            col_mask <= col_mask_nx;
            col_data <= col_data_nx;
        end
    end

    // registered commit outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_commit  <= 1'b0;
            reg_addr    <= '0;
            reg_data    <= '0;
            sram_commit <= 1'b0;
            sram_addr   <= '0;
            sram_data   <= '0;
            dir_commit  <= 1'b0;
            dir_addr    <= '0;
            dir_data    <= '0;
        end else begin
            reg_commit  <= reg_go;
            sram_commit <= sram_go;
            dir_commit  <= dir_go;
            if (reg_go) begin
                reg_addr <= tag;
                reg_data <= reg_val;
            end
            if (sram_go) begin
                sram_addr <= tag;
                sram_data <= mrg_data[2*LANE_W-1:0];
            end
            if (dir_go) begin
                dir_addr <= wr_addr;
                dir_data <= wr_data[LANE_W-1:0];
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_commit, sram_commit, dir_commit}));                       // R3
    AST_COMMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_commit || sram_commit || dir_commit) |-> $past(wr_valid));       // R3
    AST_DESC_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && cls == CLS_DESC && wr_lanes[3]) |=> reg_commit);          // R6
    AST_DESC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && cls == CLS_DESC && !wr_lanes[3] && state != ST_EMPTY && !hit)
        |=> ($stable(col_tag) && $stable(col_mask)));                          // R8
    AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (TIMER_ERRATUM && wr_valid && cls == CLS_DIRECT && timer_p0)
        |=> (state == ST_EMPTY && col_mask == 4'h0));                          // R10
endmodule

// File: tb/wcol_top_bench.sv
module wcol_top_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic [19:0]  wr_addr = '0;
    logic         wr_qword = 1'b0;
    logic [63:0]  wr_data = '0;
    logic         reg_commit, sram_commit, dir_commit;
    logic [19:0]  reg_addr, sram_addr, dir_addr;
    logic [127:0] reg_data;
    logic [63:0]  sram_data;
    logic [31:0]  dir_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wcol_top u_wcol_top (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_qword(wr_qword), .wr_data(wr_data),
        .reg_commit(reg_commit), .reg_addr(reg_addr), .reg_data(reg_data),
        .sram_commit(sram_commit), .sram_addr(sram_addr), .sram_data(sram_data),
        .dir_commit(dir_commit), .dir_addr(dir_addr), .dir_data(dir_data)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // place a 32-bit value into lane n of a 128-bit word
    function automatic logic [127:0] lane(input int n, input logic [31:0] v);
        return {96'h0, v} << (32 * n);
    endfunction

    // one write; on return the result of the write is visible
    task automatic wr(input logic [19:0] a, input bit q, input logic [63:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_qword = q; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic no_commit(input string req);
        chk(!reg_commit && !sram_commit, req, {126'h0, reg_commit, sram_commit}, 128'h0);
    endtask

    task automatic exp_reg(input string req, input logic [19:0] a, input logic [127:0] d);
        chk(reg_commit, req, {127'h0, reg_commit}, 128'h1);
        chk(reg_addr == a, req, {108'h0, reg_addr}, {108'h0, a});
        chk(reg_data == d, req, reg_data, d);
    endtask

    initial begin
        int wd;
        wd = 0;
        while (wd < 100000) begin @(posedge clk); wd++; end
        errors++; checks++;
        $display("FAIL watchdog act=%0d exp=done", wd);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] e;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1: reset state
        chk(!reg_commit && !sram_commit && !dir_commit, "R1",
            {125'h0, reg_commit, sram_commit, dir_commit}, 128'h0);
        wr(20'h00104, 0, 64'h11); wr(20'h00108, 0, 64'h22); wr(20'h0010C, 0, 64'h33);
        no_commit("R1");
        wr(20'h00100, 0, 64'h44);       // completes 0x100
        exp_reg("R2", 20'h00100, lane(0,32'h44)|lane(1,32'h11)|lane(2,32'h22)|lane(3,32'h33));

        // R2: dwords out of order
        wr(20'h00128, 0, 64'hA2); no_commit("R2");
        wr(20'h00120, 0, 64'hA0); wr(20'h0012C, 0, 64'hA3); no_commit("R2");
        wr(20'h00124, 0, 64'hA1);
        exp_reg("R2", 20'h00120, lane(0,32'hA0)|lane(1,32'hA1)|lane(2,32'hA2)|lane(3,32'hA3));
        idle();
        chk(!reg_commit, "R3", {127'h0, reg_commit}, 128'h0);

        // R2: qwords high half first
        wr(20'h00208, 1, 64'hBBBB0003_BBBB0002); no_commit("R2");
        wr(20'h00200, 1, 64'hBBBB0001_BBBB0000);
        exp_reg("R2", 20'h00200, 128'hBBBB0003_BBBB0002_BBBB0001_BBBB0000);

        // R4: restart loses the earlier partial
        wr(20'h00300, 0, 64'hC0);
        wr(20'h00310, 1, 64'h2_00000001); wr(20'h00318, 1, 64'h4_00000003);
        exp_reg("R4", 20'h00310, 128'h4_00000003_00000002_00000001);
        wr(20'h00304, 0, 64'hC1); wr(20'h00308, 0, 64'hC2); wr(20'h0030C, 0, 64'hC3);
        no_commit("R4");
        wr(20'h00300, 0, 64'hC4);
        exp_reg("R4", 20'h00300, lane(0,32'hC4)|lane(1,32'hC1)|lane(2,32'hC2)|lane(3,32'hC3));

        // R5: SRAM halves and qword
        wr(20'h80044, 0, 64'hD1); no_commit("R5");
        wr(20'h80040, 0, 64'hD0);
        chk(sram_commit && sram_addr == 20'h80040 && sram_data == 64'hD1_000000D0, "R5",
            {44'h0, sram_addr, sram_data}, {44'h0, 20'h80040, 64'hD1_000000D0});
        wr(20'h8004C, 1, 64'h12345678_9ABCDEF0);
        chk(sram_commit && sram_addr == 20'h80048 && sram_data == 64'h12345678_9ABCDEF0, "R5",
            {44'h0, sram_addr, sram_data}, {44'h0, 20'h80048, 64'h12345678_9ABCDEF0});

        // R6: top-dword-only descriptor commits with zero low part
        wr(20'h0083C, 0, 64'hFFFF_0000E5E5);
        exp_reg("R6", 20'h00830, lane(3,32'h0000E5E5));
        wr(20'h00A18, 1, 64'h77777777_66666666);
        exp_reg("R6", 20'h00A10, lane(3,32'h77777777));

        // R7 / R11: full descriptor in page 5
        wr(20'h0AA10, 0, 64'h70); wr(20'h0AA14, 0, 64'h71); wr(20'h0AA18, 0, 64'h72);
        no_commit("R11");
        wr(20'h0AA1C, 0, 64'h73);
        exp_reg("R7", 20'h0AA10, lane(0,32'h70)|lane(1,32'h71)|lane(2,32'h72)|lane(3,32'h73));

        // R8: stray descriptor write dropped
        wr(20'h00500, 0, 64'h50);
        wr(20'h00834, 0, 64'hBAD); no_commit("R8");
        wr(20'h00504, 0, 64'h51); wr(20'h00508, 0, 64'h52); wr(20'h0050C, 0, 64'h53);
        exp_reg("R8", 20'h00500, lane(0,32'h50)|lane(1,32'h51)|lane(2,32'h52)|lane(3,32'h53));

        // R9: direct write bypasses collector
        wr(20'h00600, 0, 64'h60);
        wr(20'h00400, 0, 64'hFFFFFFFF_00000E0E);
        chk(dir_commit && dir_addr == 20'h00400 && dir_data == 32'h0E0E, "R9",
            {76'h0, dir_addr, dir_data}, {76'h0, 20'h00400, 32'h0E0E});
        wr(20'h00604, 0, 64'h61); wr(20'h00608, 0, 64'h62); wr(20'h0060C, 0, 64'h63);
        exp_reg("R9", 20'h00600, lane(0,32'h60)|lane(1,32'h61)|lane(2,32'h62)|lane(3,32'h63));

        // R10: timer write in page 0 empties the collector
        wr(20'h00700, 0, 64'h80); wr(20'h00704, 0, 64'h81);
        wr(20'h00420, 0, 64'h9);
        chk(dir_commit && dir_addr == 20'h00420, "R10", {108'h0, dir_addr}, {108'h0, 20'h00420});
        wr(20'h00708, 0, 64'h82); wr(20'h0070C, 0, 64'h83);
        no_commit("R10");
        wr(20'h00700, 0, 64'h84); wr(20'h00704, 0, 64'h85);
        exp_reg("R10", 20'h00700, lane(0,32'h84)|lane(1,32'h85)|lane(2,32'h82)|lane(3,32'h83));
        // R10: timer in page 1 keeps the collector
        wr(20'h00800, 0, 64'h90); wr(20'h00804, 0, 64'h91); wr(20'h00808, 0, 64'h92);
        wr(20'h02420, 0, 64'h1);
        wr(20'h0080C, 0, 64'h93);
        exp_reg("R10", 20'h00800, lane(0,32'h90)|lane(1,32'h91)|lane(2,32'h92)|lane(3,32'h93));

        // R2 / R11: random registers, pages and orders
        for (int it = 0; it < 40; it++) begin
            logic [19:0] base;
            int ord [4];
            logic [31:0] v [4];
            bit q;
            base = {1'b0, 6'($urandom % 64), 4'h0, 4'($urandom % 16), 4'h0};
            q = 1'($urandom % 2);
            for (int k = 0; k < 4; k++) begin ord[k] = k; v[k] = $urandom; end
            for (int k = 3; k > 0; k--) begin
                int j, t;
                j = $urandom % (k + 1);
                t = ord[k]; ord[k] = ord[j]; ord[j] = t;
            end
            e = lane(0,v[0]) | lane(1,v[1]) | lane(2,v[2]) | lane(3,v[3]);
            if (q) begin
                int first;
                first = ord[0] % 2;
                wr(base + 20'(8 * first), 1, {v[2*first+1], v[2*first]});
                no_commit("R11");
                wr(base + 20'(8 * (1 - first)), 1, {v[3-2*first], v[2-2*first]});
            end else begin
                for (int k = 0; k < 4; k++) begin
                    wr(base + 20'(4 * ord[k]), 0, {32'h0, v[ord[k]]});
                    if (k == 2) no_commit("R2");
                end
            end
            exp_reg("R2", base, e);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule